// File: doc/BRIEF.md
# Cascadable Offset Counter

A synchronous binary up-counter with a registered state, a synchronous clear, a synchronous parallel load and two count enables. All state changes happen on the rising clock edge only; no input acts immediately. A carry-out goes high when the state is all ones and the carry-chain enable is high. Several counters can therefore be chained. The carry-out of one stage drives the carry-chain enable of the next stage, which gives a wider synchronous counter.

A build-time mode turns the same counter into an offset counter.

- **Start-offset mode:** the carry-out condition reloads a start value, so the sequence runs from that value up to all ones and then starts again.
- **End-offset mode:** a decode of a terminal value clears the state, so the sequence runs from zero up to that value and then returns to zero.

Both variants use only the synchronous load and clear paths. No intermediate state ever appears on the output.

Top module: `offset_counter`

## Requirements
- R1: When `clr_n` is low at a rising edge, the state becomes 0 at that edge, whatever `load_n`, `en_p`, `en_t` and `din` hold.
- R2: When `clr_n` is high and `load_n` is low at a rising edge, the state takes `din` at that edge, whether or not counting is enabled.
- R3: With `clr_n` and `load_n` high, the state increments by one, modulo 2^WIDTH, only when `en_p` and `en_t` are both high. Otherwise it holds its value.
- R4: `carry` is high exactly when the state is all ones and `en_t` is high. It does not depend on `en_p`.
- R5: With two stages chained, the low stage's `carry` drives the high stage's `en_t` and the high stage's `en_p` is tied high. The 8-bit value {high, low} then increments by one per enabled cycle and wraps from 255 to 0.
- R6: In start-offset mode (MODE=1), an enabled count from all ones loads START_VAL (default 6). The sequence is 6, 7, …, 15, 6.
- R7: In end-offset mode (MODE=2), an enabled count from END_VAL (default 13) returns the state to 0. The sequence is 0, 1, …, 13, 0.
- R8: In both offset modes, an external clear or load at the wrap state takes precedence over the automatic reload or clear.
- R9: In both offset modes, the wrap state is held when `en_p` or `en_t` is low. The automatic reload or clear only happens on an enabled count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Count enable, local only |
| en_t | input | 1 | Count enable that also gates `carry` |
| din | input | WIDTH | Parallel load value |
| q | output | WIDTH | Counter state |
| carry | output | 1 | All-ones indication gated by `en_t`, used for chaining |

## Verification
The assertions check the following on every cycle:
- the clear, load, hold and increment rules;
- the gating of `carry` by `en_t`;
- the wrap transition of whichever offset mode is built.

Only the bench scenarios can show the complete offset sequences over two full wraps in each mode. The same holds for the 8-bit result of two chained stages. The bench also shows the priority of an external load or clear at the exact wrap state, and the hold of that state with one enable low.

// File: rtl/offset_counter.sv
module offset_counter #(
  parameter int WIDTH     = 4,
  parameter int MODE      = 0,
  parameter int START_VAL = 6,
  parameter int END_VAL   = 13
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry
);
  localparam logic [WIDTH-1:0] ONE     = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] RESTART = START_VAL[WIDTH-1:0];
  localparam logic [WIDTH-1:0] LAST    = END_VAL[WIDTH-1:0];

  logic [WIDTH-1:0] state, nxt, wrap_val;
  logic             wrap_hit;

  wire advance = en_p & en_t;
  wire at_top  = &state;

  assign carry = at_top & en_t;
  assign q     = state;

  generate
    if (MODE == 1) begin : g_start
      assign wrap_hit = at_top;
      assign wrap_val = RESTART;
    end else if (MODE == 2) begin : g_end
      assign wrap_hit = (state == LAST);
      assign wrap_val = '0;
    end else begin : g_plain
      assign wrap_hit = 1'b0;
      assign wrap_val = '0;
    end
  endgenerate

  always_comb begin
    if (!clr_n)       nxt = '0;
    else if (!load_n) nxt = din;
    else if (advance) nxt = wrap_hit ? wrap_val : state + ONE;
    else              nxt = state;
  end

  always_ff @(posedge clk) state <= nxt;
endmodule

// File: rtl/offset_counter_chk.sv
module offset_counter_chk #(
  parameter int WIDTH     = 4,
  parameter int MODE      = 0,
  parameter int START_VAL = 6,
  parameter int END_VAL   = 13
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             en_p,
  input logic             en_t,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             carry
);
  localparam logic [WIDTH-1:0] ONE     = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] RESTART = START_VAL[WIDTH-1:0];
  localparam logic [WIDTH-1:0] LAST    = END_VAL[WIDTH-1:0];

  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) armed <= 1'b1;

  wire run = clr_n && load_n && en_p && en_t;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!armed) !clr_n |=> q == '0); // R1
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!armed) clr_n && !load_n |=> q == $past(din)); // R2
  AST_HOLD_IDLE:  assert property (@(posedge clk) disable iff (!armed) clr_n && load_n && !(en_p && en_t) |=> $stable(q)); // R3
  AST_CARRY_TOP:  assert property (@(posedge clk) disable iff (!armed) carry |-> (&q)); // R4
  AST_CARRY_GATE: assert property (@(posedge clk) disable iff (!armed) !en_t |-> !carry); // R4

  generate
    if (MODE == 1) begin : g_start
      AST_START_WRAP: assert property (@(posedge clk) disable iff (!armed) run && (&q) |=> q == RESTART); // R6
      AST_START_STEP: assert property (@(posedge clk) disable iff (!armed) run && !(&q) |=> q == $past(q) + ONE); // R3
    end else if (MODE == 2) begin : g_end
      AST_END_WRAP: assert property (@(posedge clk) disable iff (!armed) run && q == LAST |=> q == '0); // R7
      AST_END_STEP: assert property (@(posedge clk) disable iff (!armed) run && q != LAST |=> q == $past(q) + ONE); // R3
    end else begin : g_plain
      AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!armed) run |=> q == $past(q) + ONE); // R3
    end
  endgenerate
endmodule

bind offset_counter offset_counter_chk #(
  .WIDTH(WIDTH), .MODE(MODE), .START_VAL(START_VAL), .END_VAL(END_VAL)
) u_chk (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
  .din(din), .q(q), .carry(carry)
);

// File: tb/offset_counter_tb.sv
module offset_counter_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       clr_n = 1'b1, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] q_lo, q_hi, q_st, q_en;
  logic       c_lo, c_hi, c_st, c_en;

  offset_counter #(.MODE(0)) u_dut (.clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(q_lo), .carry(c_lo));
  offset_counter #(.MODE(0)) u_hi  (.clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(1'b1), .en_t(c_lo),
    .din(din), .q(q_hi), .carry(c_hi));
  offset_counter #(.MODE(1), .START_VAL(6)) u_st (.clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p),
    .en_t(en_t), .din(din), .q(q_st), .carry(c_st));
  offset_counter #(.MODE(2), .END_VAL(13)) u_en (.clk(clk), .clr_n(clr_n), .load_n(load_n), .en_p(en_p),
    .en_t(en_t), .din(din), .q(q_en), .carry(c_en));

  typedef struct {
    logic [3:0] lo, hi, st, en;
    logic       cy;
    string      req;
  } item_t;

  item_t q_exp[$];
  int checks = 0, errors = 0;
  logic [3:0] m_lo, m_hi, m_st, m_en;

  function automatic logic [3:0] model(logic [3:0] s, logic c, logic l, logic p, logic t,
                                       logic [3:0] d, int mode);
    if (!c) return 4'd0;
    if (!l) return d;
    if (!(p && t)) return s;
    if (mode == 1 && s == 4'd15) return 4'd6;
    if (mode == 2 && s == 4'd13) return 4'd0;
    return s + 4'd1;
  endfunction

  task automatic step(logic c, logic l, logic p, logic t, logic [3:0] d, string req);
    item_t it;
    logic  t_hi;
    @(negedge clk);
    clr_n = c; load_n = l; en_p = p; en_t = t; din = d;
    t_hi = (m_lo == 4'd15) && t;
    m_hi = model(m_hi, c, l, 1'b1, t_hi, d, 0);
    m_lo = model(m_lo, c, l, p, t, d, 0);
    m_st = model(m_st, c, l, p, t, d, 1);
    m_en = model(m_en, c, l, p, t, d, 2);
    it.lo = m_lo; it.hi = m_hi; it.st = m_st; it.en = m_en;
    it.cy = (m_lo == 4'd15) && t;
    it.req = req;
    q_exp.push_back(it);
  endtask

  task automatic cmp(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (q_exp.size() > 0) begin
      item_t it;
      it = q_exp.pop_front();
      cmp(it.req, "lo", {4'd0, q_lo}, {4'd0, it.lo});
      cmp(it.req, "start", {4'd0, q_st}, {4'd0, it.st});
      cmp(it.req, "end", {4'd0, q_en}, {4'd0, it.en});
      cmp("R5", "chain8", {q_hi, q_lo}, {it.hi, it.lo});
      cmp("R4", "carry", {7'd0, c_lo}, {7'd0, it.cy});
    end
  end

  logic done = 1'b0;
  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    m_lo = 'x; m_hi = 'x; m_st = 'x; m_en = 'x;
    step(0, 0, 1, 1, 4'd9, "R1");
    step(0, 1, 1, 1, 4'd5, "R1");
    step(1, 0, 1, 1, 4'd9, "R2");
    step(1, 0, 0, 0, 4'd3, "R2");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 4'd0, "R3");
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 4'd0, "R3");
    step(0, 1, 1, 1, 4'd0, "R1");
    for (int i = 0; i < 40; i++) step(1, 1, 1, 1, 4'd0, "R6 R7 R3");
    for (int i = 0; i < 260; i++) step(1, 1, 1, 1, 4'd0, "R5");
    step(1, 0, 1, 1, 4'd15, "R2");
    step(0, 1, 1, 1, 4'd0, "R8");
    step(1, 0, 1, 1, 4'd15, "R2");
    step(1, 0, 1, 1, 4'd3, "R8");
    step(1, 0, 1, 1, 4'd13, "R2");
    step(1, 0, 1, 1, 4'd2, "R8");
    step(1, 0, 1, 1, 4'd15, "R2");
    step(1, 1, 0, 1, 4'd0, "R9");
    step(1, 1, 1, 0, 4'd0, "R9");
    step(1, 0, 1, 1, 4'd13, "R2");
    step(1, 1, 0, 1, 4'd0, "R9");
    step(1, 1, 1, 0, 4'd0, "R9");
    step(1, 1, 1, 1, 4'd0, "R7");
    step(1, 1, 0, 0, 4'd0, "R3");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule